// File: doc/BRIEF.md
# Mixed-Width Accumulator Subtract Unit

This block is the subtract datapath of a fixed-point signal-processing core, together with the registers it works on. It holds two 36-bit accumulators (A and B), a 32-bit Y register made of two 16-bit halves (Y1 upper, Y0 lower) and a 16-bit register X0. Each accumulator is a 4-bit extension above a 16-bit upper word and a 16-bit lower word. A one-cycle start strobe names a source and a destination. One clock edge later the unit writes destination minus source back into the destination and updates five status flags. All data is two's complement, so the same hardware serves integer and fractional data.

The destination sets the operation width. An accumulator destination gets a 36-bit subtract, and a 16-bit source is placed in the accumulator's upper word with zeros below it and sign bits above it. The Y destination gets a 32-bit subtract. A 16-bit destination gets a 16-bit subtract, and an accumulator source then gives only its upper word. A source and destination pair that cannot be served changes nothing.

A control sequencer has three states. In `ST_IDLE` the unit waits. The transition *accept* (start seen in `ST_IDLE` or `ST_DONE`) latches the select codes and moves to `ST_CALC`. The transition *commit* (`ST_CALC` to `ST_DONE`) always happens and writes the result. In `ST_DONE` the done output is high. From `ST_DONE` the transition *retire* returns to `ST_IDLE` when start is low, and *accept* goes straight back to `ST_CALC` when start is high. A load port preloads any register directly.

Top module: `mwsub_unit`

## Requirements
- R1: A synchronous active-high reset clears X0, Y0, Y1, A, B and all flags to zero, and holds done low.
- R2: A start sampled high at rising edge k (while the unit is idle or showing done) writes its result and flags at edge k+1. Done is high for exactly the one cycle after edge k+1. A start sampled at edge k+1 (the busy cycle) is ignored. A start during the done cycle begins a new operation at once.
- R3: With an accumulator destination and a 16-bit source (X0, Y0 or Y1), the operand is the source with 16 zero bits appended below it, sign-extended to 36 bits. The accumulator's lower word is therefore unchanged. Example: A = 4:8058:1234 minus Y0 = 8003 gives 5:0055:1234.
- R4: With an accumulator destination and Y as the source, Y (Y1 upper, Y0 lower) is sign-extended from 32 to 36 bits and subtracted.
- R5: With an accumulator destination and an accumulator source (including itself), a full 36-bit subtract is performed.
- R6: With a 16-bit destination (X0, Y0 or Y1), a 16-bit subtract is performed and only that register is written. An accumulator source contributes only its upper word (bits 31:16).
- R7: With Y as the destination, a 32-bit subtract is written to Y1:Y0. A 16-bit source is placed in the upper half with zeros below it, Y as the source is used whole, and an accumulator source gives its lower 32 bits with the extension ignored.
- R8: On every legal operation, flags are computed at the operation width w (16, 32 or 36): flags[3] is the result MSB, flags[2] is set when the w-bit result is zero, flags[1] is signed overflow of the w-bit subtract, and flags[0] is the unsigned borrow (destination < source at width w).
- R9: flags[4] is set after a 36-bit operation whose result bits 35:32 are not all equal to bit 31. It is cleared after any 16-bit or 32-bit operation.
- R10: Select codes 6 and 7 in either position, and a 16-bit destination with Y as the source, are illegal. An illegal operation leaves every register and flag unchanged, but done still pulses.
- R11: Select codes are 0 = X0, 1 = Y0, 2 = Y1, 3 = Y, 4 = A, 5 = B. With ld_en high at an edge, the register named by ld_sel takes ld_data: the low 16 bits for a 16-bit register, the low 32 bits for Y (bits 31:16 to Y1), and all 36 bits for an accumulator. Codes 6 and 7 load nothing.
- R12: When a load and a legal commit fall on the same edge, the commit wins for every register it writes, and the load still updates registers the commit does not write. The subtract uses register values from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle operation strobe |
| src_sel | input | 3 | Source select code |
| dst_sel | input | 3 | Destination select code |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 3 | Register to load |
| ld_data | input | 36 | Load value |
| done | output | 1 | High for one cycle when an operation has finished |
| flags | output | 5 | {ext_used, negative, zero, overflow, borrow} |
| x0_q | output | 16 | X0 contents |
| y0_q | output | 16 | Y0 contents |
| y1_q | output | 16 | Y1 contents |
| a_q | output | 36 | Accumulator A contents |
| b_q | output | 36 | Accumulator B contents |

## Verification
The load port and the commit write can fall on the same clock edge. The bench provokes this by raising ld_en during the busy cycle of an operation. One case loads the register the result goes to. Another loads an unrelated accumulator. A third loads one half of Y while a 32-bit result goes to Y. In each case the bench expects the result in every register the commit writes and the load value everywhere else, and it computes the result from the values held before the edge.

// File: rtl/mwsub_pkg.sv
package mwsub_pkg;

    typedef enum logic [2:0] {
        SEL_X0  = 3'd0,
        SEL_Y0  = 3'd1,
        SEL_Y1  = 3'd2,
        SEL_Y   = 3'd3,
        SEL_A   = 3'd4,
        SEL_B   = 3'd5,
        SEL_NA6 = 3'd6,
        SEL_NA7 = 3'd7
    } rsel_e;

    typedef enum logic [1:0] {
        OPW_16,
        OPW_32,
        OPW_FULL
    } opw_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_DONE
    } st_e;

    localparam int FLG_W  = 5;
    localparam int FB_BRW = 0;
    localparam int FB_OVF = 1;
    localparam int FB_ZER = 2;
    localparam int FB_NEG = 3;
    localparam int FB_EXT = 4;

endpackage

// File: rtl/mwsub_ctrl.sv
module mwsub_ctrl
    import mwsub_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  rsel_e src_sel,
    input  rsel_e dst_sel,
    output rsel_e src_q,
    output rsel_e dst_q,
    output logic  commit,
    output logic  done
);

    st_e  state, state_nx;
    logic accept;

    assign accept = start && (state == ST_IDLE || state == ST_DONE);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // operand selects are latched on accept only
    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= SEL_X0;
            dst_q <= SEL_X0;
        end else if (accept) begin
            src_q <= src_sel;
            dst_q <= dst_sel;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_CALC;
            ST_CALC: state_nx = ST_DONE;
            ST_DONE: state_nx = start ? ST_CALC : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit = (state == ST_CALC);
        done   = (state == ST_DONE);
    end

    assert_done_from_start_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start, 2));

    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/mwsub_align.sv
module mwsub_align
    import mwsub_pkg::*;
#(
    parameter  int EXT_W  = 4,
    parameter  int WORD_W = 16,
    localparam int LONG_W = 2 * WORD_W,
    localparam int ACC_W  = EXT_W + LONG_W
)(
    input  rsel_e              src,
    input  rsel_e              dst,
    input  logic [WORD_W-1:0]  x0,
    input  logic [WORD_W-1:0]  y0,
    input  logic [WORD_W-1:0]  y1,
    input  logic [ACC_W-1:0]   acc_a,
    input  logic [ACC_W-1:0]   acc_b,
    output logic [ACC_W-1:0]   d_op,
    output logic [ACC_W-1:0]   s_op,
    output opw_e               opw,
    output logic               legal
);

    logic [WORD_W-1:0] s_word, d_word;
    logic [ACC_W-1:0]  s_acc, d_acc;
    logic              s_is_word, s_is_y, s_is_acc;

    always_comb begin
        s_is_word = (src == SEL_X0) || (src == SEL_Y0) || (src == SEL_Y1);
        s_is_y    = (src == SEL_Y);
        s_is_acc  = (src == SEL_A) || (src == SEL_B);
        s_word    = (src == SEL_X0) ? x0 : (src == SEL_Y0) ? y0 : y1;
        d_word    = (dst == SEL_X0) ? x0 : (dst == SEL_Y0) ? y0 : y1;
        s_acc     = (src == SEL_A) ? acc_a : acc_b;
        d_acc     = (dst == SEL_A) ? acc_a : acc_b;
    end

    always_comb begin
        legal = 1'b1;
        opw   = OPW_FULL;
        d_op  = '0;
        s_op  = '0;
        unique case (dst)
            SEL_A, SEL_B: begin
                opw  = OPW_FULL;
                d_op = d_acc;
                if (s_is_word)
                    s_op = {{EXT_W{s_word[WORD_W-1]}}, s_word, {WORD_W{1'b0}}};
                else if (s_is_y)
                    s_op = {{EXT_W{y1[WORD_W-1]}}, y1, y0};
                else if (s_is_acc)
                    s_op = s_acc;
                else
                    legal = 1'b0;
            end
            SEL_Y: begin
                opw  = OPW_32;
                d_op = {{EXT_W{1'b0}}, y1, y0};
                if (s_is_word)
                    s_op = {{EXT_W{1'b0}}, s_word, {WORD_W{1'b0}}};
                else if (s_is_y)
                    s_op = {{EXT_W{1'b0}}, y1, y0};
                else if (s_is_acc)
                    s_op = {{EXT_W{1'b0}}, s_acc[LONG_W-1:0]};
                else
                    legal = 1'b0;
            end
            SEL_X0, SEL_Y0, SEL_Y1: begin
                opw  = OPW_16;
                d_op = {{(ACC_W-WORD_W){1'b0}}, d_word};
                if (s_is_word)
                    s_op = {{(ACC_W-WORD_W){1'b0}}, s_word};
                else if (s_is_acc)
                    s_op = {{(ACC_W-WORD_W){1'b0}}, s_acc[LONG_W-1:WORD_W]};
                else
                    legal = 1'b0;
            end
            default: legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/mwsub_alu.sv
module mwsub_alu
    import mwsub_pkg::*;
#(
    parameter  int EXT_W  = 4,
    parameter  int WORD_W = 16,
    localparam int LONG_W = 2 * WORD_W,
    localparam int ACC_W  = EXT_W + LONG_W
)(
    input  logic [ACC_W-1:0] d_op,
    input  logic [ACC_W-1:0] s_op,
    input  opw_e             opw,
    output logic [ACC_W-1:0] res,
    output logic [FLG_W-1:0] flg
);

    logic [ACC_W:0] diff;
    logic dm, sm, rm, brw, zr, ext;

    always_comb begin
        diff = {1'b0, d_op} - {1'b0, s_op};
        res  = diff[ACC_W-1:0];
        unique case (opw)
            OPW_16: begin
                dm  = d_op[WORD_W-1];
                sm  = s_op[WORD_W-1];
                rm  = diff[WORD_W-1];
                brw = diff[WORD_W];
                zr  = (diff[WORD_W-1:0] == '0);
                ext = 1'b0;
            end
            OPW_32: begin
                dm  = d_op[LONG_W-1];
                sm  = s_op[LONG_W-1];
                rm  = diff[LONG_W-1];
                brw = diff[LONG_W];
                zr  = (diff[LONG_W-1:0] == '0);
                ext = 1'b0;
            end
            default: begin
                dm  = d_op[ACC_W-1];
                sm  = s_op[ACC_W-1];
                rm  = diff[ACC_W-1];
                brw = diff[ACC_W];
                zr  = (diff[ACC_W-1:0] == '0);
                ext = (diff[ACC_W-1:LONG_W] != {EXT_W{diff[LONG_W-1]}});
            end
        endcase
        flg         = '0;
        flg[FB_NEG] = rm;
        flg[FB_ZER] = zr;
        flg[FB_OVF] = (dm ^ sm) & (rm ^ dm);
        flg[FB_BRW] = brw;
        flg[FB_EXT] = ext;
    end

endmodule

// File: rtl/mwsub_unit.sv
module mwsub_unit
    import mwsub_pkg::*;
#(
    parameter  int EXT_W  = 4,
    parameter  int WORD_W = 16,
    localparam int LONG_W = 2 * WORD_W,
    localparam int ACC_W  = EXT_W + LONG_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        src_sel,
    input  logic [2:0]        dst_sel,
    input  logic              ld_en,
    input  logic [2:0]        ld_sel,
    input  logic [ACC_W-1:0]  ld_data,
    output logic              done,
    output logic [FLG_W-1:0]  flags,
    output logic [WORD_W-1:0] x0_q,
    output logic [WORD_W-1:0] y0_q,
    output logic [WORD_W-1:0] y1_q,
    output logic [ACC_W-1:0]  a_q,
    output logic [ACC_W-1:0]  b_q
);

    rsel_e            src_q, dst_q;
    logic             commit, legal;
    logic [ACC_W-1:0] d_op, s_op, res;
    logic [FLG_W-1:0] flg_nx;
    opw_e             opw;

    mwsub_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .src_sel (rsel_e'(src_sel)),
        .dst_sel (rsel_e'(dst_sel)),
        .src_q   (src_q),
        .dst_q   (dst_q),
        .commit  (commit),
        .done    (done)
    );

    mwsub_align #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_align (
        .src   (src_q),
        .dst   (dst_q),
        .x0    (x0_q),
        .y0    (y0_q),
        .y1    (y1_q),
        .acc_a (a_q),
        .acc_b (b_q),
        .d_op  (d_op),
        .s_op  (s_op),
        .opw   (opw),
        .legal (legal)
    );

    mwsub_alu #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_alu (
        .d_op (d_op),
        .s_op (s_op),
        .opw  (opw),
        .res  (res),
        .flg  (flg_nx)
    );

    // register file: load first, commit last so the commit wins on overlap
    always_ff @(posedge clk) begin
        if (rst) begin
            x0_q  <= '0;
            y0_q  <= '0;
            y1_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            flags <= '0;
        end else begin
            if (ld_en) begin
                case (rsel_e'(ld_sel))
                    SEL_X0: x0_q <= ld_data[WORD_W-1:0];
                    SEL_Y0: y0_q <= ld_data[WORD_W-1:0];
                    SEL_Y1: y1_q <= ld_data[WORD_W-1:0];
                    SEL_Y: begin
                        y1_q <= ld_data[LONG_W-1:WORD_W];
                        y0_q <= ld_data[WORD_W-1:0];
                    end
                    SEL_A:  a_q <= ld_data;
                    SEL_B:  b_q <= ld_data;
                    default: ;
                endcase
            end
            if (commit && legal) begin
                case (dst_q)
                    SEL_X0: x0_q <= res[WORD_W-1:0];
                    SEL_Y0: y0_q <= res[WORD_W-1:0];
                    SEL_Y1: y1_q <= res[WORD_W-1:0];
                    SEL_Y: begin
                        y1_q <= res[LONG_W-1:WORD_W];
                        y0_q <= res[WORD_W-1:0];
                    end
                    SEL_A:  a_q <= res;
                    SEL_B:  b_q <= res;
                    default: ;
                endcase
                flags <= flg_nx;
            end
        end
    end

    assert_low_word_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (commit && legal && dst_q == SEL_A && !ld_en &&
         (src_q == SEL_X0 || src_q == SEL_Y0 || src_q == SEL_Y1))
        |=> $stable(a_q[WORD_W-1:0]));

    assert_word_dest_only_R6: assert property (@(posedge clk) disable iff (rst)
        (commit && legal && dst_q == SEL_X0 && !ld_en)
        |=> ($stable(a_q) && $stable(b_q) && $stable(y0_q) && $stable(y1_q)));

    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (commit && legal && dst_q == SEL_X0)
        |=> (flags[FB_ZER] == (x0_q == '0)));

    assert_ext_flag_narrow_R9: assert property (@(posedge clk) disable iff (rst)
        (commit && legal && dst_q != SEL_A && dst_q != SEL_B)
        |=> !flags[FB_EXT]);

    assert_illegal_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (commit && !legal && !ld_en)
        |=> ($stable(flags) && $stable(x0_q) && $stable(y0_q) && $stable(y1_q)
             && $stable(a_q) && $stable(b_q)));

endmodule

// File: tb/sim_mwsub_unit.sv
module sim_mwsub_unit;
    import mwsub_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  src_sel = '0, dst_sel = '0, ld_sel = '0;
    logic        ld_en = 1'b0;
    logic [35:0] ld_data = '0;
    logic        done;
    logic [4:0]  flags;
    logic [15:0] x0_q, y0_q, y1_q;
    logic [35:0] a_q, b_q;

    always #10 clk = ~clk;

    mwsub_unit u0 (
        .clk(clk), .rst(rst), .start(start), .src_sel(src_sel), .dst_sel(dst_sel),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data), .done(done), .flags(flags),
        .x0_q(x0_q), .y0_q(y0_q), .y1_q(y1_q), .a_q(a_q), .b_q(b_q)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] m_x0, m_y0, m_y1;
    logic [35:0] m_a, m_b;
    logic [4:0]  m_f;

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_regs(string tag, string ftag);
        chk(x0_q == m_x0, tag, "x0", 64'(x0_q), 64'(m_x0));
        chk(y0_q == m_y0, tag, "y0", 64'(y0_q), 64'(m_y0));
        chk(y1_q == m_y1, tag, "y1", 64'(y1_q), 64'(m_y1));
        chk(a_q  == m_a,  tag, "a",  64'(a_q),  64'(m_a));
        chk(b_q  == m_b,  tag, "b",  64'(b_q),  64'(m_b));
        chk(flags == m_f, ftag, "flags", 64'(flags), 64'(m_f));
    endtask

    function automatic logic [15:0] mword(int c);
        if (c == 0) return m_x0;
        if (c == 1) return m_y0;
        return m_y1;
    endfunction

    function automatic logic [4:0] pmask(int c);
        case (c)
            0: return 5'b00001;
            1: return 5'b00010;
            2: return 5'b00100;
            3: return 5'b00110;
            4: return 5'b01000;
            5: return 5'b10000;
            default: return 5'b00000;
        endcase
    endfunction

    task automatic model_load(int c, logic [35:0] v);
        case (c)
            0: m_x0 = v[15:0];
            1: m_y0 = v[15:0];
            2: m_y1 = v[15:0];
            3: begin m_y1 = v[31:16]; m_y0 = v[15:0]; end
            4: m_a = v;
            5: m_b = v;
            default: ;
        endcase
    endtask

    // Expected result computed from the requirement text (R3..R10)
    task automatic model_op(int s, int d, output bit ok);
        logic [63:0] dv, sv, r, mask;
        logic [15:0] wv;
        int w;
        ok = 1; dv = '0; sv = '0; w = 36;
        wv = mword(s);
        if (d == 4 || d == 5) begin
            w = 36;
            dv = (d == 4) ? 64'(m_a) : 64'(m_b);
            if (s <= 2)      sv = {28'h0, {4{wv[15]}}, wv, 16'h0};
            else if (s == 3) sv = {28'h0, {4{m_y1[15]}}, m_y1, m_y0};
            else if (s == 4) sv = 64'(m_a);
            else if (s == 5) sv = 64'(m_b);
            else ok = 0;
        end else if (d == 3) begin
            w = 32;
            dv = {32'h0, m_y1, m_y0};
            if (s <= 2)      sv = {32'h0, wv, 16'h0};
            else if (s == 3) sv = dv;
            else if (s == 4) sv = {32'h0, m_a[31:0]};
            else if (s == 5) sv = {32'h0, m_b[31:0]};
            else ok = 0;
        end else if (d <= 2) begin
            w = 16;
            dv = 64'(mword(d));
            if (s <= 2)      sv = 64'(wv);
            else if (s == 4) sv = 64'(m_a[31:16]);
            else if (s == 5) sv = 64'(m_b[31:16]);
            else ok = 0;
        end else ok = 0;
        if (ok) begin
            mask = (64'h1 << w) - 64'h1;
            r = (dv - sv) & mask;
            m_f[0] = (dv < sv);
            m_f[1] = (dv[w-1] != sv[w-1]) && (r[w-1] != dv[w-1]);
            m_f[2] = (r == 64'h0);
            m_f[3] = r[w-1];
            m_f[4] = (w == 36) && (r[35:32] != {4{r[31]}});
            case (d)
                0: m_x0 = r[15:0];
                1: m_y0 = r[15:0];
                2: m_y1 = r[15:0];
                3: begin m_y1 = r[31:16]; m_y0 = r[15:0]; end
                4: m_a = r[35:0];
                default: m_b = r[35:0];
            endcase
        end
    endtask

    function automatic string tag_for(int s, int d);
        if (s > 5 || d > 5 || (d <= 2 && s == 3)) return "R10";
        if (d >= 4 && s <= 2) return "R3";
        if (d >= 4 && s == 3) return "R4";
        if (d >= 4) return "R5";
        if (d == 3) return "R7";
        return "R6";
    endfunction

    function automatic logic [35:0] pv(int p, int i);
        logic [63:0] h;
        if (p == 0) begin
            case (i)
                0: return 36'h0_0000_8000;
                1: return 36'h0_0000_7FFF;
                2: return 36'h0_0000_FFFF;
                3: return 36'h7_FFFF_FFFF;
                default: return 36'h8_0000_0000;
            endcase
        end
        if (p == 1) begin
            case (i)
                0: return 36'h0;
                1: return 36'h0_0000_8000;
                2: return 36'h0_0000_8000;
                3: return 36'h0_8000_0000;
                default: return 36'hF_8000_0000;
            endcase
        end
        h = (64'(p + 1) * 64'h9E3779B97F4A7C15) ^ (64'(i + 7) * 64'hC2B2AE3D27D4EB4F);
        h = h ^ (h >> 29);
        h = h * 64'hBF58476D1CE4E5B9;
        h = h ^ (h >> 32);
        return h[35:0];
    endfunction

    task automatic load_one(int c, logic [35:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 3'(c); ld_data = v;
        model_load(c, v);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic load_set(int p);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            ld_en = 1'b1;
            ld_sel = (i < 3) ? 3'(i) : 3'(i + 1);
            ld_data = pv(p, i);
            model_load(int'(ld_sel), ld_data);
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // start at negedge, busy cycle, then done cycle where results are checked
    task automatic run_op(int s, int d);
        bit ok;
        @(negedge clk);
        start = 1'b1; src_sel = 3'(s); dst_sel = 3'(d);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(done == 1'b1, (s > 5 || d > 5) ? "R10" : "R2", "done", 64'(done), 64'd1);
        model_op(s, d, ok);
        check_regs(tag_for(s, d), ok ? "R8 R9" : "R10");
    endtask

    // load issued in the busy cycle so it shares the commit edge (R12)
    task automatic run_op_ld(int s, int d, int lc, logic [35:0] lv);
        bit ok;
        @(negedge clk);
        start = 1'b1; src_sel = 3'(s); dst_sel = 3'(d);
        @(negedge clk);
        start = 1'b0;
        ld_en = 1'b1; ld_sel = 3'(lc); ld_data = lv;
        @(negedge clk);
        ld_en = 1'b0;
        chk(done == 1'b1, "R12", "done", 64'(done), 64'd1);
        model_op(s, d, ok);
        if (!(ok && ((pmask(lc) & pmask(d)) != 5'b0))) model_load(lc, lv);
        else if (lc == 3 && d != 3) model_load(lc, lv);
        check_regs("R12", "R12");
    endtask

    initial begin
        bit ok;
        m_x0 = '0; m_y0 = '0; m_y1 = '0; m_a = '0; m_b = '0; m_f = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(done == 1'b0, "R1", "done", 64'(done), 64'd0);
        check_regs("R1", "R1");

        // R3: worked example from the requirement
        load_one(4, 36'h4_8058_1234);
        load_one(1, 36'h0_0000_8003);
        @(negedge clk);
        start = 1'b1; src_sel = 3'd1; dst_sel = 3'd4;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(a_q == 36'h5_0055_1234, "R3", "example a", 64'(a_q), 64'h5_0055_1234);
        chk(flags == 5'b10001, "R9", "example flags", 64'(flags), 64'b10001);
        model_op(1, 4, ok);

        // R11: loads of every code, codes 6 and 7 ignored
        load_one(3, 36'hA_1234_5678);
        check_regs("R11", "R11");
        load_one(6, 36'hF_FFFF_FFFF);
        check_regs("R11", "R11");
        load_one(7, 36'hF_FFFF_FFFF);
        check_regs("R11", "R11");

        // near-exhaustive sweep: every select pair over several value sets
        for (int p = 0; p < 8; p++)
            for (int d = 0; d < 8; d++)
                for (int s = 0; s < 8; s++) begin
                    load_set(p);
                    run_op(s, d);
                end

        // R2: cycle timing, back-to-back start in done cycle, start ignored while busy
        load_set(2);
        @(negedge clk);
        start = 1'b1; src_sel = 3'd1; dst_sel = 3'd4;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R2", "done in busy cycle", 64'(done), 64'd0);
        chk(a_q == m_a, "R2", "a before commit", 64'(a_q), 64'(m_a));
        @(negedge clk);
        chk(done == 1'b1, "R2", "done", 64'(done), 64'd1);
        model_op(1, 4, ok);
        check_regs("R2", "R2");
        start = 1'b1; src_sel = 3'd0; dst_sel = 3'd5;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R2", "back-to-back busy", 64'(done), 64'd0);
        @(negedge clk);
        chk(done == 1'b1, "R2", "back-to-back done", 64'(done), 64'd1);
        model_op(0, 5, ok);
        check_regs("R2", "R2");
        @(negedge clk);
        start = 1'b1; src_sel = 3'd4; dst_sel = 3'd5;
        @(negedge clk);
        src_sel = 3'd5; dst_sel = 3'd4;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R2", "held start done", 64'(done), 64'd1);
        model_op(4, 5, ok);
        check_regs("R2", "R2");
        @(negedge clk);
        chk(done == 1'b0, "R2", "busy start ignored", 64'(done), 64'd0);
        check_regs("R2", "R2");

        // R12: load and commit on the same edge
        load_set(3);
        run_op_ld(1, 0, 0, 36'h0_0000_1111);
        load_set(4);
        run_op_ld(0, 1, 4, 36'h3_3333_3333);
        load_set(5);
        run_op_ld(0, 3, 1, 36'h0_0000_2222);
        load_set(6);
        run_op_ld(4, 3, 5, 36'h9_8765_4321);

        // R1: reset in mid-run clears everything
        load_set(7);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_x0 = '0; m_y0 = '0; m_y1 = '0; m_a = '0; m_b = '0; m_f = '0;
        chk(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);
        check_regs("R1", "R1");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule